// File: doc/BRIEF.md
# Dual-Loop Lock Detector with Test-Output Selector

This block watches two phase-locked loops that share one reference: a main loop and an auxiliary loop. For each loop it pairs every reference edge with the nearest divided-feedback edge. It judges the loop in lock when the two edges of each pair land less than one reference period apart. The period itself is measured in system clocks between consecutive reference edges. A loop whose divider is switched off by its enable bit counts as locked whatever its phase. The two per-loop verdicts are combined by AND and drive a single output pin.

The same pin doubles as a test point. A 2-bit select field, qualified by a flag that says whether the field has been loaded, can route one of three divider terminal-count strobes to the pin in place of the lock indication. Each strobe keeps its own idle polarity. All pin values pass through one output register.

Top module: `dual_loop_lock`

## Requirements
- R1: While the synchronous reset is high, and at the first clock after it, the pin is low and the pin source is the lock function.
- R2: In lock mode the pin is high only when both the main and the auxiliary loop are judged locked; one unlocked enabled loop forces it low.
- R3: An enabled loop whose feedback edges recur at the reference rate is judged locked, whether the feedback edge leads or lags the reference edge, for any offset of less than one reference period.
- R4: An enabled loop that receives no feedback edge between consecutive reference edges is judged unlocked.
- R5: A loop whose enable input is 0 is judged locked regardless of its feedback edges, so with both enables at 0 the pin in lock mode is high.
- R6: After reset no enabled loop is judged locked until the reference period has been measured. That needs two reference edges, and the verdict first turns high on the third reference edge.
- R7: Each per-loop verdict changes only on a clock in which a reference edge is present, so it holds steady for a whole reference period.
- R8: When the loaded flag is 0, the select code has no effect and the pin carries the lock function; code 00 with the flag at 1 does the same.
- R9: Code 01 (flag at 1) puts the reference-divider strobe on the pin: idle low, high for one clock per terminal-count pulse.
- R10: Code 10 (flag at 1) puts the auxiliary-divider strobe on the pin inverted: idle high, low for one clock per pulse.
- R11: Code 11 (flag at 1) puts the main-divider strobe on the pin inverted: idle high, low for one clock per pulse.
- R12: Every pin value, in every mode, appears exactly one clock after the inputs that produce it are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_edge | input | 1 | One-clock pulse per reference edge |
| main_fb_edge | input | 1 | One-clock pulse per main-loop feedback edge |
| aux_fb_edge | input | 1 | One-clock pulse per auxiliary-loop feedback edge |
| main_en | input | 1 | Main-loop divider enabled |
| aux_en | input | 1 | Auxiliary-loop divider enabled |
| tsel | input | 2 | Pin source code: 00 lock, 01 reference strobe, 10 auxiliary strobe, 11 main strobe |
| tsel_loaded | input | 1 | High when tsel holds a loaded value |
| ref_tc | input | 1 | Reference-divider terminal-count pulse |
| aux_tc | input | 1 | Auxiliary-divider terminal-count pulse |
| main_tc | input | 1 | Main-divider terminal-count pulse |
| lock_pin | output | 1 | Lock indication or selected strobe, registered |

## Verification
The bench drives feedback edges at the largest leading and lagging offsets, with an edge one clock inside the reference period. A detector that compared against the period with the wrong bound would drop lock there. It also removes a loop's feedback while that loop is disabled, which a design ignoring the enable would report as unlocked. The bench checks the pin across the first reference edges after reset, where a design that trusted an unmeasured period would raise lock too early. In strobe modes it toggles the loaded flag and the code under random terminal-count pulses. A swapped polarity, a missing register stage or a select that ignores the flag each shows up as a pin value one cycle off or inverted.

// File: rtl/lockdet_pkg.sv
`timescale 1ns/1ps
package lockdet_pkg;

    typedef enum logic [1:0] {
        PIN_LOCK    = 2'b00,
        PIN_REFDIV  = 2'b01,
        PIN_AUXDIV  = 2'b10,
        PIN_MAINDIV = 2'b11
    } pin_src_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT_FB,
        PH_WAIT_REF
    } ph_state_e;

    typedef struct packed {
        logic ref_tc;
        logic aux_tc;
        logic main_tc;
    } div_strobes_t;

    function automatic pin_src_e effective_src(logic loaded, logic [1:0] code);
        return loaded ? pin_src_e'(code) : PIN_LOCK;
    endfunction

    function automatic logic pin_value(pin_src_e src, logic lock_now, div_strobes_t st);
        logic v;
        case (src)
            PIN_REFDIV:  v = st.ref_tc;
            PIN_AUXDIV:  v = ~st.aux_tc;
            PIN_MAINDIV: v = ~st.main_tc;
            default:     v = lock_now;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ref_period_meter.sv
`timescale 1ns/1ps
module ref_period_meter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_edge,
    output logic [CNT_W-1:0] period,
    output logic             period_valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] since_ref;
    logic             seen_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_ref    <= '0;
            period       <= '0;
            seen_one     <= 1'b0;
            period_valid <= 1'b0;
        end else if (ref_edge) begin
            since_ref <= {{(CNT_W-1){1'b0}}, 1'b1};
            seen_one  <= 1'b1;
            if (seen_one) begin
                period       <= since_ref;
                period_valid <= 1'b1;
            end
        end else if (since_ref != CNT_MAX) begin
            since_ref <= since_ref + 1'b1;
        end
    end

    // R6
    valid_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(period_valid) |-> $past(ref_edge));

endmodule

// File: rtl/loop_phase_judge.sv
`timescale 1ns/1ps
module loop_phase_judge
    import lockdet_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_edge,
    input  logic             fb_edge,
    input  logic [CNT_W-1:0] period,
    input  logic             period_valid,
    output logic             locked
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    ph_state_e        state, state_n;
    logic [CNT_W-1:0] elapsed, elapsed_n;
    logic             miss_now, miss_acc, locked_q, timeout;

    assign timeout = (elapsed >= period);

    always_comb begin
        state_n   = state;
        elapsed_n = (elapsed != CNT_MAX) ? elapsed + 1'b1 : elapsed;
        miss_now  = 1'b0;
        case (state)
            PH_IDLE: begin
                if (ref_edge && fb_edge) begin
                    state_n = PH_IDLE;
                end else if (ref_edge) begin
                    state_n   = PH_WAIT_FB;
                    elapsed_n = CNT_ONE;
                end else if (fb_edge) begin
                    state_n   = PH_WAIT_REF;
                    elapsed_n = CNT_ONE;
                end
            end
            PH_WAIT_FB: begin
                if (fb_edge) begin
                    miss_now = timeout;
                    state_n  = PH_IDLE;
                end else if (ref_edge) begin
                    miss_now  = 1'b1;
                    elapsed_n = CNT_ONE;
                end else if (timeout) begin
                    miss_now = 1'b1;
                    state_n  = PH_IDLE;
                end
            end
            PH_WAIT_REF: begin
                if (ref_edge) begin
                    miss_now = timeout;
                    state_n  = PH_IDLE;
                end else if (fb_edge) begin
                    miss_now  = 1'b1;
                    elapsed_n = CNT_ONE;
                end else if (timeout) begin
                    miss_now = 1'b1;
                    state_n  = PH_IDLE;
                end
            end
            default: state_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PH_IDLE;
            elapsed  <= '0;
            miss_acc <= 1'b0;
            locked_q <= 1'b0;
        end else begin
            state   <= state_n;
            elapsed <= elapsed_n;
            if (ref_edge) begin
                locked_q <= period_valid && !miss_acc && !miss_now;
                miss_acc <= 1'b0;
            end else if (miss_now) begin
                miss_acc <= 1'b1;
            end
        end
    end

    assign locked = locked_q;

    // R7
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_edge |=> $stable(locked_q));

    // R6
    verdict_needs_period_chk: assert property (@(posedge clk) disable iff (rst)
        locked_q |-> period_valid);

endmodule

// File: rtl/pin_output_stage.sv
`timescale 1ns/1ps
module pin_output_stage
    import lockdet_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  pin_src_e     src,
    input  logic         lock_now,
    input  div_strobes_t strobes,
    output logic         pin
);
    always_ff @(posedge clk) begin
        if (rst) pin <= 1'b0;
        else     pin <= pin_value(src, lock_now, strobes);
    end

    // R9
    ref_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (src == PIN_REFDIV) |=> (pin == $past(strobes.ref_tc)));

endmodule

// File: rtl/dual_loop_lock.sv
`timescale 1ns/1ps
module dual_loop_lock
    import lockdet_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_edge,
    input  logic       main_fb_edge,
    input  logic       aux_fb_edge,
    input  logic       main_en,
    input  logic       aux_en,
    input  logic [1:0] tsel,
    input  logic       tsel_loaded,
    input  logic       ref_tc,
    input  logic       aux_tc,
    input  logic       main_tc,
    output logic       lock_pin
);
    localparam int N_LOOPS = 2;

    logic [CNT_W-1:0]   period;
    logic               period_valid;
    logic [N_LOOPS-1:0] fb_vec, en_vec, verdict, loop_ok;
    logic               lock_now;
    pin_src_e           src;
    div_strobes_t       strobes;

    assign fb_vec = {aux_fb_edge, main_fb_edge};
    assign en_vec = {aux_en, main_en};

    ref_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst(rst), .ref_edge(ref_edge),
        .period(period), .period_valid(period_valid)
    );

    for (genvar g = 0; g < N_LOOPS; g++) begin : g_loop
        loop_phase_judge #(.CNT_W(CNT_W)) u_judge (
            .clk(clk), .rst(rst), .ref_edge(ref_edge), .fb_edge(fb_vec[g]),
            .period(period), .period_valid(period_valid), .locked(verdict[g])
        );
        assign loop_ok[g] = !en_vec[g] || verdict[g];
    end

    assign lock_now = &loop_ok;
    assign src      = effective_src(tsel_loaded, tsel);
    assign strobes  = '{ref_tc: ref_tc, aux_tc: aux_tc, main_tc: main_tc};

    pin_output_stage u_pin (
        .clk(clk), .rst(rst), .src(src), .lock_now(lock_now),
        .strobes(strobes), .pin(lock_pin)
    );

    // R2
    lock_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        (src == PIN_LOCK && !(loop_ok[0] && loop_ok[1])) |=> !lock_pin);

    // R5
    both_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (src == PIN_LOCK && !main_en && !aux_en) |=> lock_pin);

    // R8
    unloaded_is_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !tsel_loaded |=> (lock_pin == $past(lock_now)));

    // R10
    aux_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (tsel_loaded && tsel == 2'b10 && !aux_tc) |=> lock_pin);

    // R11
    main_pulse_low_chk: assert property (@(posedge clk) disable iff (rst)
        (tsel_loaded && tsel == 2'b11 && main_tc) |=> !lock_pin);

endmodule

// File: tb/test_dual_loop_lock.sv
`timescale 1ns/1ps
module test_dual_loop_lock;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_edge = 0, main_fb_edge = 0, aux_fb_edge = 0;
    logic main_en = 0, aux_en = 0;
    logic [1:0] tsel = 2'b00;
    logic tsel_loaded = 0;
    logic ref_tc = 0, aux_tc = 0, main_tc = 0;
    logic lock_pin;

    int checks = 0;
    int fails  = 0;

    int  per = 8;
    int  moff = 0, aoff = 0;
    bit  mpres = 0, apres = 0;
    int  sc = 0;

    always #2 clk = ~clk;

    dual_loop_lock i_dual_loop_lock (
        .clk(clk), .rst(rst), .ref_edge(ref_edge),
        .main_fb_edge(main_fb_edge), .aux_fb_edge(aux_fb_edge),
        .main_en(main_en), .aux_en(aux_en), .tsel(tsel), .tsel_loaded(tsel_loaded),
        .ref_tc(ref_tc), .aux_tc(aux_tc), .main_tc(main_tc), .lock_pin(lock_pin)
    );

    function automatic bit exp_lock(bit men, bit mp, bit aen, bit ap);
        return (!men || mp) && (!aen || ap);
    endfunction

    function automatic bit exp_pin(bit loaded, bit [1:0] code, bit lk, bit r, bit a, bit m);
        if (!loaded) return lk;
        case (code)
            2'b01:   return r;
            2'b10:   return !a;
            2'b11:   return !m;
            default: return lk;
        endcase
    endfunction

    function automatic string mode_tag(bit loaded, bit [1:0] code);
        if (!loaded) return "R8";
        case (code)
            2'b01:   return "R9";
            2'b10:   return "R10";
            2'b11:   return "R11";
            default: return "R8";
        endcase
    endfunction

    function automatic bit hit(int c, int off, int p);
        return (((c - off) % p) + p) % p == 0;
    endfunction

    task automatic check(string tag, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: lock_pin=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive_cycle();
        ref_edge     = hit(sc, 0, per);
        main_fb_edge = mpres && hit(sc, moff, per);
        aux_fb_edge  = apres && hit(sc, aoff, per);
        sc++;
    endtask

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            drive_cycle();
            @(negedge clk);
        end
    endtask

    task automatic scenario(int p, int mo, int ao, bit men, bit aen, bit mp, bit ap, string tag);
        int bad;
        bit e;
        per = p; moff = mo; aoff = ao;
        main_en = men; aux_en = aen; mpres = mp; apres = ap;
        run_cycles(6 * p);
        e = exp_lock(men, mp, aen, ap);
        bad = 0;
        for (int i = 0; i < 2 * p; i++) begin
            if (lock_pin !== e) bad++;
            drive_cycle();
            @(negedge clk);
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: lock_pin=%0b expected %0b (P=%0d moff=%0d aoff=%0d en=%0b%0b pres=%0b%0b)",
                     tag, !e, e, p, mo, ao, men, aen, mp, ap);
        end
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit pl, pr, pa, pm;
        bit [1:0] pc;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", lock_pin, 1'b0);
        rst = 1'b0;
        check("R1", lock_pin, 1'b0);
        // R12, R5: both loops disabled -> lock high one clock after release
        @(negedge clk);
        check("R12", lock_pin, 1'b1);

        // R6: lock only after two reference edges measured
        rst = 1'b1;
        main_en = 1; aux_en = 1; mpres = 1; apres = 1;
        per = 8; moff = 0; aoff = 2;
        @(negedge clk); @(negedge clk);
        rst = 1'b0; sc = 0;
        run_cycles(17);
        check("R6", lock_pin, 1'b0);
        run_cycles(1);
        check("R3", lock_pin, 1'b1);

        // Directed corners
        scenario(10, 0, 0, 1, 1, 1, 1, "R2");
        scenario(12, -11, 11, 1, 1, 1, 1, "R3");
        scenario(9, 8, -8, 1, 1, 1, 1, "R3");
        scenario(10, 0, 3, 1, 1, 0, 1, "R4");
        scenario(10, 4, 0, 1, 1, 1, 0, "R2");
        scenario(16, 5, 0, 1, 1, 1, 1, "R7");
        scenario(10, 0, 2, 0, 1, 0, 1, "R5");
        scenario(14, 3, 0, 1, 0, 1, 0, "R5");
        scenario(6, 0, 0, 0, 0, 0, 0, "R5");
        scenario(11, 2, 2, 1, 1, 1, 1, "R7");

        // Random scenarios
        for (int k = 0; k < 24; k++) begin
            int p;
            int mo, ao;
            p  = 4 + int'($urandom % 37);
            mo = int'($urandom % (2 * p - 1)) - (p - 1);
            ao = int'($urandom % (2 * p - 1)) - (p - 1);
            scenario(p, mo, ao, bit'($urandom % 2), bit'($urandom % 2),
                     bit'($urandom % 3 != 0), bit'($urandom % 3 != 0), "R4");
        end

        // Strobe modes: loops disabled so lock function is high
        main_en = 0; aux_en = 0; mpres = 0; apres = 0;
        per = 1000000;
        ref_edge = 0; main_fb_edge = 0; aux_fb_edge = 0;
        tsel_loaded = 1; tsel = 2'b01;
        ref_tc = 0; aux_tc = 0; main_tc = 0;
        pl = tsel_loaded; pc = tsel; pr = 0; pa = 0; pm = 0;
        @(negedge clk);
        for (int i = 0; i < 600; i++) begin
            check(mode_tag(pl, pc), lock_pin, exp_pin(pl, pc, 1'b1, pr, pa, pm));
            if (i % 25 == 0) begin
                tsel        = 2'($urandom % 4);
                tsel_loaded = ($urandom % 4) != 0;
            end
            ref_tc  = ($urandom % 3) == 0;
            aux_tc  = ($urandom % 3) == 0;
            main_tc = ($urandom % 3) == 0;
            pl = tsel_loaded; pc = tsel; pr = ref_tc; pa = aux_tc; pm = main_tc;
            @(negedge clk);
        end

        // R12: a lone pulse appears exactly one clock later
        tsel_loaded = 1; tsel = 2'b01;
        ref_tc = 0; aux_tc = 0; main_tc = 0;
        @(negedge clk);
        ref_tc = 1;
        check("R12", lock_pin, 1'b0);
        @(negedge clk);
        ref_tc = 0;
        check("R12", lock_pin, 1'b1);
        @(negedge clk);
        check("R12", lock_pin, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule